// File: doc/BRIEF.md
# CAN bit timing generator

This block divides the system clock into time quanta and runs each nominal CAN bit through four segments in order: synchronisation, propagation, phase 1 and phase 2. At the end of phase 1 it captures the bus level and raises a one-cycle sample strobe. When the synchronisation quantum of a new bit completes, it raises a one-cycle bit-start strobe. A frame engine sits on top of it and uses the two strobes as its bit clock.

The bus-receive input is examined once per quantum. A recessive-to-dominant transition seen while the bus is idle restarts the bit (hard synchronisation). A transition seen while a frame is in progress moves the bit boundary by no more than the jump width (resynchronisation). All timing fields are stored as the value minus one. Software must change them only while `en` is low. A valid setting has phase 2 of at least two quanta, a jump width no larger than phase 1, and a bit length of 8 to 25 quanta.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts `cfg_brp`+1 clock cycles. Every strobe and segment change happens on a quantum boundary. After `en` rises, the first bit-start strobe comes exactly one quantum later.
- R2: If no falling edge is seen, consecutive bit-start strobes are 1+P+T1+T2 quanta apart. Here P=`cfg_prop`+1, T1=`cfg_ph1`+1 and T2=`cfg_ph2`+1.
- R3: The sample strobe comes P+T1 quanta after the bit-start strobe. `sample_bit` takes the `rx` level at that quantum boundary and keeps it until the next sample.
- R4: `segment` is encoded as 0 sync, 1 propagation, 2 phase 1 and 3 phase 2. In the cycle of a bit-start strobe it reads 1, and in the cycle of a sample strobe it reads 3.
- R5: While idle, a falling edge ends the current quantum as a synchronisation quantum. The bit-start strobe appears at that boundary and the bit timing restarts from there.
- R6: The block is idle after enable. A hard synchronisation clears the idle state. It becomes idle again after 11 consecutive recessive samples. While not idle, an edge never causes a hard synchronisation.
- R7: A falling edge in quantum k of the bit (k=1 is the first propagation quantum), inside propagation or phase 1, lengthens phase 1 by min(SJW, k). SJW is `cfg_sjw`+1.
- R8: A falling edge in phase 2 with e quanta of phase 2 remaining, counting the current one, behaves as follows. If e ≤ SJW, the current quantum becomes the sync quantum of a new bit. Otherwise phase 2 is shortened by SJW.
- R9: Rising edges have no effect on timing. A falling edge inside the sync quantum of a bit that is not idle has no effect on timing.
- R10: Only the first falling edge of a bit resynchronises. Later edges in the same bit are ignored.
- R11: While `en` is low, both strobes are low, `segment` reads 0 and the quantum divider is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low holds the block cleared |
| rx | input | 1 | Synchronised bus level, 1 = recessive |
| cfg_brp | input | 7 | Quantum divide ratio minus one |
| cfg_prop | input | 3 | Propagation length minus one |
| cfg_ph1 | input | 3 | Phase 1 length minus one |
| cfg_ph2 | input | 3 | Phase 2 length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| sample_pulse | output | 1 | One-cycle strobe at the sample point |
| sample_bit | output | 1 | Bus level captured at the last sample point |
| bit_start | output | 1 | One-cycle strobe when a bit's sync quantum completes |
| segment | output | 2 | Segment of the quantum now in progress |

## Verification
The bench sweeps propagation and phase 1 lengths with two prescalers and two phase 2 lengths. For each setting it measures where the strobes fall. An off-by-one in a minus-one field would move every strobe by one quantum.

A second, hand-computed scenario places falling edges at chosen quanta:
- Late edges below and above the jump width check that phase 1 grows by exactly the clipped error. A missing clip would stretch the bit.
- Early edges with remaining error above and below the jump width tell "shorten phase 2" apart from "start a new bit now".
- A second edge in one bit, a rising edge and an edge in the sync quantum must all leave the timing unchanged.
- A falling edge after eleven recessive samples must hard-synchronise rather than resynchronise.

// File: rtl/cbt_pkg.sv
// Shared types for the CAN bit timing generator.
package cbt_pkg;
    // Segment encoding seen on the segment output.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_t;
endpackage

// File: rtl/cbt_prescaler.sv
// Quantum divider: emits a one-cycle tick every div_m1+1 clocks.
// Assumes div_m1 is stable while en is high; the count is cleared while en is low.
module cbt_prescaler #(
    parameter int BRP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [BRP_W-1:0] div_m1,
    output logic             tick
);
    logic [BRP_W-1:0] cnt;

    assign tick = en && (cnt == div_m1);

    // Count clocks within the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (cnt == div_m1)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cbt_edge_det.sv
// Falling-edge detector sampled once per quantum.
// Assumes rx is already synchronised to clk; the previous level resets to recessive.
module cbt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic rx,
    output logic fall
);
    logic prev_rx;

    assign fall = tick && prev_rx && !rx;

    // Remember the bus level at the previous quantum boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            prev_rx <= 1'b1;
        else if (tick)
            prev_rx <= rx;
    end
endmodule

// File: rtl/cbt_idle_mon.sv
// Bus idle tracker: idle after enable, cleared by hard sync, set again
// after IDLE_BITS consecutive recessive samples.
// Assumes sample is a one-cycle strobe at the sample point.
module cbt_idle_mon #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sample,
    input  logic rx,
    input  logic hsync,
    output logic idle
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    logic [CW-1:0] rec_cnt;

    // Count recessive samples in a row and flag bus idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            idle    <= 1'b1;
            rec_cnt <= '0;
        end else if (hsync) begin
            idle    <= 1'b0;
            rec_cnt <= '0;
        end else if (sample) begin
            if (!rx)
                rec_cnt <= '0;
            else if (rec_cnt == CW'(IDLE_BITS - 1))
                idle <= 1'b1;
            else
                rec_cnt <= rec_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cbt_sequencer.sv
// Segment sequencer: walks sync, propagation, phase 1 and phase 2 one quantum
// at a time, and applies hard sync and jump-width limited resynchronisation.
// Assumes the configuration is valid and stable while en is high.
module cbt_sequencer
    import cbt_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             fall,
    input  logic             idle,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_ph1,
    input  logic [SEG_W-1:0] cfg_ph2,
    input  logic [SJW_W-1:0] cfg_sjw,
    output seg_t             seg,
    output logic             hsync,
    output logic             sample_now,
    output logic             bit_now
);
    localparam int LEN_W = SEG_W + 2;

    logic [LEN_W-1:0] qcnt, ext, cut;
    logic             synced;
    logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
    logic [LEN_W-1:0] pos_late, ext_add, ph1_eff, ph2_eff, err_early, cut_add;
    logic             edge_q, resync_ok, early_end, seg_last;
    seg_t             seg_next;

    // Decode lengths, phase errors and the end of the current segment.
    always_comb begin
        prop_len  = LEN_W'(cfg_prop) + LEN_W'(1);
        ph1_len   = LEN_W'(cfg_ph1) + LEN_W'(1);
        ph2_len   = LEN_W'(cfg_ph2) + LEN_W'(1);
        sjw_len   = LEN_W'(cfg_sjw) + LEN_W'(1);
        edge_q    = tick && fall;
        hsync     = edge_q && idle;
        resync_ok = edge_q && !idle && !synced && (seg != SEG_SYNC);
        pos_late  = (seg == SEG_PROP) ? qcnt + LEN_W'(1) : prop_len + qcnt + LEN_W'(1);
        ext_add   = '0;
        if (resync_ok && (seg == SEG_PROP || seg == SEG_PH1))
            ext_add = (pos_late < sjw_len) ? pos_late : sjw_len;
        ph1_eff   = ph1_len + ext + ext_add;
        ph2_eff   = ph2_len - cut;
        err_early = ph2_eff - qcnt;
        early_end = resync_ok && (seg == SEG_PH2) && (err_early <= sjw_len);
        cut_add   = (resync_ok && (seg == SEG_PH2) && !early_end) ? sjw_len : '0;
        case (seg)
            SEG_SYNC: begin seg_last = 1'b1;                          seg_next = SEG_PROP; end
            SEG_PROP: begin seg_last = (qcnt == prop_len - 1'b1);     seg_next = SEG_PH1;  end
            SEG_PH1:  begin seg_last = (qcnt == ph1_eff - 1'b1);      seg_next = SEG_PH2;  end
            default:  begin seg_last = (qcnt == ph2_eff - cut_add - 1'b1); seg_next = SEG_SYNC; end
        endcase
        bit_now    = tick && (hsync || early_end || seg == SEG_SYNC);
        sample_now = tick && !hsync && (seg == SEG_PH1) && seg_last;
    end

    // Advance the segment state once per quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            seg    <= SEG_SYNC;
            qcnt   <= '0;
            ext    <= '0;
            cut    <= '0;
            synced <= 1'b0;
        end else if (tick) begin
            if (bit_now) begin
                seg    <= SEG_PROP;
                qcnt   <= '0;
                ext    <= '0;
                cut    <= '0;
                synced <= 1'b0;
            end else begin
                ext <= ext + ext_add;
                cut <= cut + cut_add;
                if (resync_ok)
                    synced <= 1'b1;
                if (seg_last) begin
                    seg  <= seg_next;
                    qcnt <= '0;
                end else begin
                    qcnt <= qcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
// CAN bit timing generator top: quantum divider, edge detector, idle tracker
// and segment sequencer, with registered strobes.
// Assumes rx is synchronised to clk and the configuration changes only while en is low.
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int BRP_W     = 7,
    parameter int SEG_W     = 3,
    parameter int SJW_W     = 2,
    parameter int IDLE_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_ph1,
    input  logic [SEG_W-1:0] cfg_ph2,
    input  logic [SJW_W-1:0] cfg_sjw,
    output logic             sample_pulse,
    output logic             sample_bit,
    output logic             bit_start,
    output logic [1:0]       segment
);
    logic tick, fall, idle, hsync, sample_now, bit_now;
    seg_t seg;

    assign segment = seg;

    cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(en), .div_m1(cfg_brp), .tick(tick)
    );

    cbt_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rx(rx), .fall(fall)
    );

    cbt_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk(clk), .rst_n(rst_n), .en(en), .sample(sample_now), .rx(rx),
        .hsync(hsync), .idle(idle)
    );

    cbt_sequencer #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .fall(fall), .idle(idle),
        .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
        .seg(seg), .hsync(hsync), .sample_now(sample_now), .bit_now(bit_now)
    );

    // Register the strobes and capture the bus level at the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sample_pulse <= 1'b0;
            bit_start    <= 1'b0;
            sample_bit   <= 1'b0;
        end else begin
            sample_pulse <= sample_now;
            bit_start    <= bit_now;
            if (sample_now)
                sample_bit <= rx;
        end
    end
endmodule

// File: rtl/cbt_checker.sv
// Protocol checker for can_bit_timer, attached with bind.
module cbt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       sample_pulse,
    input logic       sample_bit,
    input logic       bit_start,
    input logic [1:0] segment
);
    // R3 / R4: the two strobes never coincide
    p_strobes_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_start && sample_pulse));

    // R4: a new bit always continues into propagation
    p_start_to_prop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> segment == 2'd1);

    // R4: sample point is the entry into phase 2
    p_sample_to_ph2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |-> segment == 2'd3);

    // R4: segments advance in order or restart at propagation
    p_seg_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && segment != $past(segment)) |->
            (segment == $past(segment) + 2'd1) || (segment == 2'd1));

    // R3: captured bit only moves with a sample strobe
    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !sample_pulse) |-> $stable(sample_bit));

    // R11: disabling clears the strobes and the segment
    p_disable_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sample_pulse && !bit_start && segment == 2'd0));
endmodule

bind can_bit_timer cbt_checker u_cbt_checker (
    .clk(clk), .rst_n(rst_n), .en(en), .sample_pulse(sample_pulse),
    .sample_bit(sample_bit), .bit_start(bit_start), .segment(segment)
);

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       rx = 1'b1;
    logic [6:0] cfg_brp = '0;
    logic [2:0] cfg_prop = '0, cfg_ph1 = '0, cfg_ph2 = '0;
    logic [1:0] cfg_sjw = '0;
    logic       sample_pulse, sample_bit, bit_start;
    logic [1:0] segment;

    int n_chk = 0;
    int n_fail = 0;
    int tq = 0;
    int q_len = 1;

    always #2 clk = ~clk;

    can_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .rx(rx), .cfg_brp(cfg_brp),
        .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
        .sample_pulse(sample_pulse), .sample_bit(sample_bit),
        .bit_start(bit_start), .segment(segment)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one quantum and land between edges.
    task automatic step_q();
        repeat (q_len) @(posedge clk);
        @(negedge clk);
        tq++;
    endtask

    // Step until the chosen strobe shows (0 = bit start, 1 = sample).
    task automatic next_ev(input int which, output int t);
        t = -1;
        for (int i = 0; i < 80; i++) begin
            step_q();
            if ((which == 0) ? bit_start : sample_pulse) begin
                t = tq;
                break;
            end
        end
    endtask

    task automatic restart(input int brp, input int prop, input int ph1, input int ph2, input int sjw);
        @(negedge clk);
        en = 1'b0;
        cfg_brp = 7'(brp); cfg_prop = 3'(prop); cfg_ph1 = 3'(ph1);
        cfg_ph2 = 3'(ph2); cfg_sjw = 2'(sjw);
        rx = 1'b1;
        @(negedge clk);
        en = 1'b1;
        tq = 0;
        q_len = brp + 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R11
        chk(!bit_start && !sample_pulse && segment == 2'd0, "R11 reset", int'(segment), 0);

        // Config: Q=2, P=3, T1=3, T2=3, SJW=2, bit = 10 quanta
        restart(1, 2, 2, 2, 1);
        next_ev(0, t); chk(t == 1, "R1 first bit start", t, 1);
        step_q(); step_q();
        rx = 1'b0;                                  // edge at quantum 3, idle
        next_ev(0, t); chk(t == 4, "R5 hard sync", t, 4);
        chk(segment == 2'd1, "R4 prop after start", int'(segment), 1);
        next_ev(1, t); chk(t == 10, "R3 sample point", t, 10);
        chk(sample_bit == 1'b0, "R3 sample_bit", int'(sample_bit), 0);
        chk(segment == 2'd3, "R4 ph2 after sample", int'(segment), 3);
        rx = 1'b1;                                  // rising edge in ph2
        next_ev(0, t); chk(t == 14, "R9 rising ignored", t, 14);
        rx = 1'b0;                                  // late edge k=1
        next_ev(1, t); chk(t == 21, "R7 late k=1 sample", t, 21);
        next_ev(0, t); chk(t == 25, "R7 R6 late k=1 no hard sync", t, 25);
        rx = 1'b1;
        while (tq < 29) step_q();
        rx = 1'b0;                                  // late edge k=5, clipped to 2
        next_ev(1, t); chk(t == 33, "R7 late clipped sample", t, 33);
        rx = 1'b1;
        step_q();
        rx = 1'b0;                                  // second edge in same bit
        next_ev(0, t); chk(t == 37, "R10 second edge ignored", t, 37);
        rx = 1'b1;
        next_ev(1, t); chk(t == 43, "R3 sample recessive", t, 43);
        chk(sample_bit == 1'b1, "R3 sample_bit", int'(sample_bit), 1);
        rx = 1'b0;                                  // early edge e=3 > SJW
        next_ev(0, t); chk(t == 45, "R8 ph2 shortened", t, 45);
        rx = 1'b1;
        next_ev(1, t); chk(t == 51, "R3 sample", t, 51);
        step_q();
        rx = 1'b0;                                  // early edge e=2 <= SJW
        next_ev(0, t); chk(t == 53, "R8 early new bit", t, 53);
        rx = 1'b1;
        while (tq < 62) step_q();
        rx = 1'b0;                                  // edge inside sync quantum
        next_ev(0, t); chk(t == 63, "R9 sync edge", t, 63);
        next_ev(0, t); chk(t == 73, "R9 R2 sync edge no shift", t, 73);
        rx = 1'b1;
        for (int i = 0; i < 12; i++) next_ev(0, t);
        chk(t == 193, "R2 recessive run", t, 193);
        step_q(); step_q();
        rx = 1'b0;                                  // idle again: hard sync
        next_ev(0, t); chk(t == 196, "R6 idle regained", t, 196);

        // R11: disable mid-bit
        @(negedge clk);
        en = 1'b0;
        rx = 1'b1;
        @(negedge clk);
        chk(!bit_start && !sample_pulse && segment == 2'd0, "R11 disabled", int'(segment), 0);
        en = 1'b1;
        tq = 0;
        next_ev(0, t); chk(t == 1, "R11 divider restarts", t, 1);

        // Sweep of segment lengths: R1 R2 R3 R4
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 8; p++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int c = 0; c < 2; c++) begin
                        int ph2f, nq, bb;
                        ph2f = (c == 0) ? 1 : 7;
                        nq = 4 + p + a + ph2f;
                        bb = b * 2;
                        if (nq < 8 || nq > 25) continue;
                        restart(bb, p, a, ph2f, 0);
                        next_ev(0, t); chk(t == 1, "R1 sweep first start", t, 1);
                        next_ev(1, t); chk(t == 3 + p + a, "R3 sweep sample", t, 3 + p + a);
                        chk(segment == 2'd3 && sample_bit, "R4 sweep ph2", int'(segment), 3);
                        next_ev(0, t); chk(t == 1 + nq, "R2 sweep bit length", t, 1 + nq);
                        chk(segment == 2'd1, "R4 sweep prop", int'(segment), 1);
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule